// File: doc/BRIEF.md
# Registered Output Cell Bank

This block is the bank of output cells that sits after the product-term array of a programmable sum-of-products device. Each cell receives one OR sum from the array. A per-cell polarity bit can invert that sum. A per-cell mode bit then picks one of two paths. In registered mode, a D flip-flop on a clock shared by all cells captures the value. In combinational mode, the value goes straight to the pin.

Each cell returns its value to the array in both true and complemented form. In registered mode that value is the flip-flop output. In combinational mode it is the value being driven toward the pin. The pad itself sits outside the block. The block supplies the data and the enable of each pin's tri-state buffer. All registered cells share one active-low enable. Each combinational cell takes its own enable term from the array.

A synchronous reset clears every flip-flop to 0. Wiring several registered cells back through external sum logic builds state machines such as counters. The cell mode is an enumerated value: `MODE_COMB` (bit value 0) passes the sum through and `MODE_REG` (bit value 1) registers it. There are no other states and no transitions other than a configuration change.

Top module: `outcell_bank`

## Requirements
- R1: The cell value is `sum_in[i]` XOR `cfg_inv[i]`, so a polarity bit of 1 drives and stores the complement of the sum.
- R2: With `cfg_reg[i]`=1 (registered), `pad_o[i]` takes the cell value present before a rising edge of `clk` and holds it until the next rising edge. All cells load on the same edge.
- R3: In registered mode, `fb_true[i]` equals the flip-flop output and `fb_comp[i]` equals its complement.
- R4: In registered mode, `pad_en[i]` is the inverse of `glob_oe_n` in the same cycle, and `comb_oe[i]` has no effect.
- R5: With `cfg_reg[i]`=0 (combinational), `pad_o[i]` follows the cell value in the same cycle. `pad_en[i]` equals `comb_oe[i]`, and `glob_oe_n` has no effect.
- R6: In combinational mode, `fb_true[i]` equals the cell value and `fb_comp[i]` equals its complement.
- R7: In combinational mode the flip-flop holds its content. After a switch to registered mode, `pad_o[i]` shows the held value until the next rising edge.
- R8: `rst_n`=0 at a rising edge clears every flip-flop to 0, whatever the cell mode.
- R9: Four registered cells, whose sums are external logic computing `fb_true[3:0]+1`, advance a 4-bit count by one per clock and wrap from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all cell flip-flops |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flops |
| sum_in | input | N_CELLS | OR sums from the product-term array |
| cfg_inv | input | N_CELLS | Per-cell polarity: 1 inverts the sum |
| cfg_reg | input | N_CELLS | Per-cell mode: 1 registered, 0 combinational |
| comb_oe | input | N_CELLS | Per-cell enable term used in combinational mode |
| glob_oe_n | input | 1 | Common active-low enable for registered cells |
| pad_o | output | N_CELLS | Data to each pin's tri-state buffer |
| pad_en | output | N_CELLS | Enable of each pin's tri-state buffer |
| fb_true | output | N_CELLS | True feedback to the array |
| fb_comp | output | N_CELLS | Complemented feedback to the array |

## Verification
A flip-flop holding a wrong value shows at `pad_o` and on both feedback lines. It appears at the first sample after the faulty edge, and in combinational mode only once the cell is switched back to registered mode. A cell with the wrong mode shows as a one-cycle lag, or as no lag, between `sum_in` and `pad_o`. It also shows as the wrong enable source on `pad_en`. In the counter test, a fault spreads to every later count, so one bad load is seen within a cycle.

// File: rtl/outcell_pkg.sv
package outcell_pkg;
    typedef enum logic {
        MODE_COMB = 1'b0,
        MODE_REG  = 1'b1
    } cell_mode_e;
endpackage

// File: rtl/outcell_pol.sv
module outcell_pol #(
    parameter int N_CELLS = 8
) (
    input  logic [N_CELLS-1:0] sum_in,
    input  logic [N_CELLS-1:0] cfg_inv,
    output logic [N_CELLS-1:0] cell_d
);
    always_comb begin
        cell_d = sum_in ^ cfg_inv;
    end
endmodule

// File: rtl/outcell_ff.sv
module outcell_ff #(
    parameter int N_CELLS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] load_en,
    input  logic [N_CELLS-1:0] cell_d,
    output logic [N_CELLS-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~load_en) | (cell_d & load_en);
        end
    end

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q ^ $past(cell_d)) & $past(load_en)) == '0); // R2
    AST_COMB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q ^ $past(q)) & ~$past(load_en)) == '0); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> q == '0); // R8
endmodule

// File: rtl/outcell_drv.sv
module outcell_drv
    import outcell_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic [N_CELLS-1:0] cfg_reg,
    input  logic [N_CELLS-1:0] cell_d,
    input  logic [N_CELLS-1:0] q,
    input  logic [N_CELLS-1:0] comb_oe,
    input  logic               glob_oe_n,
    output logic [N_CELLS-1:0] pad_o,
    output logic [N_CELLS-1:0] pad_en,
    output logic [N_CELLS-1:0] fb_true,
    output logic [N_CELLS-1:0] fb_comp
);
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        cell_mode_e mode;
        assign mode = cell_mode_e'(cfg_reg[i]);

        always_comb begin
            unique case (mode)
                MODE_REG: begin
                    pad_o[i]   = q[i];
                    pad_en[i]  = ~glob_oe_n;
                    fb_true[i] = q[i];
                end
                MODE_COMB: begin
                    pad_o[i]   = cell_d[i];
                    pad_en[i]  = comb_oe[i];
                    fb_true[i] = cell_d[i];
                end
                default: begin
                    pad_o[i]   = 1'b0;
                    pad_en[i]  = 1'b0;
                    fb_true[i] = 1'b0;
                end
            endcase
            fb_comp[i] = ~fb_true[i];
        end
    end
endmodule

// File: rtl/outcell_bank.sv
module outcell_bank #(
    parameter int N_CELLS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] sum_in,
    input  logic [N_CELLS-1:0] cfg_inv,
    input  logic [N_CELLS-1:0] cfg_reg,
    input  logic [N_CELLS-1:0] comb_oe,
    input  logic               glob_oe_n,
    output logic [N_CELLS-1:0] pad_o,
    output logic [N_CELLS-1:0] pad_en,
    output logic [N_CELLS-1:0] fb_true,
    output logic [N_CELLS-1:0] fb_comp
);
    logic [N_CELLS-1:0] cell_d;
    logic [N_CELLS-1:0] q;

    outcell_pol #(.N_CELLS(N_CELLS)) u_pol (
        .sum_in (sum_in),
        .cfg_inv(cfg_inv),
        .cell_d (cell_d)
    );

    outcell_ff #(.N_CELLS(N_CELLS)) u_ff (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_en(cfg_reg),
        .cell_d (cell_d),
        .q      (q)
    );

    outcell_drv #(.N_CELLS(N_CELLS)) u_drv (
        .cfg_reg  (cfg_reg),
        .cell_d   (cell_d),
        .q        (q),
        .comb_oe  (comb_oe),
        .glob_oe_n(glob_oe_n),
        .pad_o    (pad_o),
        .pad_en   (pad_en),
        .fb_true  (fb_true),
        .fb_comp  (fb_comp)
    );

    AST_FB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_true ^ fb_comp) == {N_CELLS{1'b1}}); // R3
    AST_REG_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_en ^ {N_CELLS{~glob_oe_n}}) & cfg_reg) == '0); // R4
    AST_COMB_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_en ^ comb_oe) & ~cfg_reg) == '0); // R5
    AST_COMB_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb_true ^ sum_in ^ cfg_inv) & ~cfg_reg) == '0); // R6
endmodule

// File: tb/sim_outcell_bank.sv
module sim_outcell_bank;
    localparam int N = 8;

    typedef struct {
        logic [N-1:0] pad;
        logic [N-1:0] en;
        logic [N-1:0] fbt;
        logic [N-1:0] fbc;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] sum_in = '0;
    logic [N-1:0] cfg_inv = '0;
    logic [N-1:0] cfg_reg = '0;
    logic [N-1:0] comb_oe = '0;
    logic         glob_oe_n = 1'b1;
    logic [N-1:0] pad_o, pad_en, fb_true, fb_comp;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t sb[$];
    logic [N-1:0] mq = '0;

    always #10 clk = ~clk;

    outcell_bank #(.N_CELLS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .cfg_inv(cfg_inv),
        .cfg_reg(cfg_reg), .comb_oe(comb_oe), .glob_oe_n(glob_oe_n),
        .pad_o(pad_o), .pad_en(pad_en), .fb_true(fb_true), .fb_comp(fb_comp)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes what the next sample must show
    task automatic step(input logic r, input logic [N-1:0] s, input logic [N-1:0] inv,
                        input logic [N-1:0] rg, input logic [N-1:0] coe, input logic goe_n,
                        input bit count_mode, input string tag);
        exp_t e;
        logic [N-1:0] d;
        @(negedge clk);
        #2;
        if (count_mode) s = {{(N-4){1'b0}}, fb_true[3:0] + 4'd1};
        rst_n = r; sum_in = s; cfg_inv = inv; cfg_reg = rg; comb_oe = coe; glob_oe_n = goe_n;
        d = s ^ inv;
        if (!r) mq = '0;
        else    mq = (mq & ~rg) | (d & rg);
        e.pad = (mq & rg) | (d & ~rg);
        e.en  = (~rg & coe) | (rg & {N{~goe_n}});
        e.fbt = e.pad;
        e.fbc = ~e.pad;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares outputs at each falling edge against the queued item
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " pad_o"},   pad_o,   e.pad);
            check({e.tag, " pad_en"},  pad_en,  e.en);
            check({e.tag, " fb_true"}, fb_true, e.fbt);
            check({e.tag, " fb_comp"}, fb_comp, e.fbc);
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] start;
        // R8 reset state, registered cells read 0
        step(0, 8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, "R8 reset");
        step(0, 8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, "R8 reset");
        // R2 R3 registered load
        step(1, 8'hA5, 8'h00, 8'hFF, 8'h00, 0, 0, "R2 R3 load A5");
        step(1, 8'h3C, 8'h00, 8'hFF, 8'h00, 0, 0, "R2 R3 load 3C");
        // R1 polarity inversion
        step(1, 8'hA5, 8'hFF, 8'hFF, 8'h00, 0, 0, "R1 invert all");
        step(1, 8'hA5, 8'h0F, 8'hFF, 8'h00, 0, 0, "R1 invert low");
        // R4 common enable, comb_oe ignored
        step(1, 8'h00, 8'h00, 8'hFF, 8'hFF, 1, 0, "R4 oe off");
        step(1, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, "R4 oe on");
        // R5 R6 combinational, glob_oe_n ignored
        step(1, 8'h3C, 8'h0F, 8'h00, 8'h0F, 0, 0, "R5 R6 comb");
        step(1, 8'h3C, 8'h0F, 8'h00, 8'h0F, 1, 0, "R5 comb goe ignored");
        step(1, 8'hC3, 8'h00, 8'h00, 8'hF0, 0, 0, "R6 comb feedback");
        // mixed modes
        step(1, 8'h96, 8'h11, 8'hF0, 8'h0C, 0, 0, "R2 R5 mixed");
        // R7 hold: load 1s, go combinational with d=0, then switch back
        step(1, 8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, "R7 preload");
        step(1, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 0, "R7 comb d0");
        step(1, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 0, "R7 comb d0");
        step(1, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, "R7 reload");
        #1;
        check("R7 held value before edge", pad_o, 8'hFF);
        // R8 reset clears flops even in combinational cells
        step(1, 8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, "R8 preload");
        step(0, 8'hFF, 8'h00, 8'h0F, 8'h00, 0, 0, "R8 reset mixed");
        step(1, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, "R8 after reset");
        #1;
        check("R8 comb cells cleared", pad_o, 8'h00);
        // R9 counter over four registered cells
        step(1, 8'h05, 8'h00, 8'h0F, 8'h00, 0, 0, "R9 seed");
        @(negedge clk);
        #1;
        start = fb_true[3:0];
        check("R9 seed value", {4'h0, start}, 8'h05);
        for (int k = 0; k < 20; k++) begin
            step(1, '0, 8'h00, 8'h0F, 8'h00, 0, 1, "R9 count");
        end
        @(negedge clk);
        #1;
        check("R9 count after 20", {4'h0, fb_true[3:0]}, {4'h0, 4'(start + 4'd4)});
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule